// File: doc/BRIEF.md
# Dual-Rail Four-Phase Word Receiver

This block accepts a data word sent as two-wire codes per bit and turns it back into an ordinary binary word inside one clock domain. For every bit, a high level on the "true" wire means a one and a high level on the "false" wire means a zero. Both wires low is the empty (spacer) state, and both wires high is an illegal code. No separate request line exists: the arrival of a full set of codes is itself the request.

Every rail first passes through a two-stage synchronizer. A completion detector then tracks a hysteretic merge of the per-bit validity flags. The merge sets only when every bit carries a legal code and clears only when every wire is low; otherwise it keeps its state. The registered merge state is the acknowledge returned to the sender. On the cycle the merge sets, the decoded word is captured and marked by a one-cycle strobe. The sender must then return all wires to zero, and it may send the next word only after acknowledge has fallen.

Any bit seen with both wires high latches a sticky code-error flag that only reset clears.

Top module: `dr_rx`

## Requirements
- R1: While `rstN` is low and in the first cycle after it is released, `ack`, `outValid`, `codeErr` and `dataOut` are all 0.
- R2: Three rising clock edges after every bit starts carrying a legal code (exactly one wire high) and `ack` is low, `ack` goes to 1. This is two synchronizer stages plus the merge register.
- R3: `outValid` is 1 for exactly one cycle, in the same cycle that `ack` rises, and at no other time.
- R4: While any bit is in the spacer state (both wires low) and `ack` is low, `ack` stays 0.
- R5: While `ack` is high, it stays 1 as long as any wire is high. It falls three rising edges after all wires go low.
- R6: While `ack` is high, a change to another legal word without a return to zero causes no new capture. `dataOut` keeps its value and no `outValid` pulse occurs.
- R7: A bit with both wires high is never a legal code. It keeps `ack` from rising, and three edges after it appears `codeErr` goes to 1. `codeErr` then stays 1 until reset.
- R8: While `ack` is high, a bit with both wires high during the return-to-zero phase keeps `ack` at 1.
- R9: Bit i of `dataOut` equals the value of the true wire `railT[i]` of the captured word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| railT | input | WIDTH | True wire of each bit |
| railF | input | WIDTH | False wire of each bit |
| ack | output | 1 | Acknowledge to the sender (registered merge state) |
| dataOut | output | WIDTH | Last captured decoded word |
| outValid | output | 1 | One-cycle strobe marking a new word on `dataOut` |
| codeErr | output | 1 | Sticky flag set when an illegal code is seen |

## Verification
The assertions assume a sender that moves all wires of a word in the same cycle, so each word reaches the merge in one step after the synchronizer. They also assume the sender obeys the four-phase order: a new word only after `ack` has fallen, and return to zero only while `ack` is high. The stimulus follows these rules. It drives every wire change on the falling clock edge and waits for each `ack` transition before taking the next step. The deliberate breaks of the order (a word swap without return to zero, partial words, illegal codes) are applied only where the pulse, stability and sticky-flag properties must still hold.

// File: rtl/dr_pkg.sv
package dr_pkg;
  typedef struct packed {
    logic captureEn;
    logic errSet;
  } ctlStrobes_t;
endpackage

// File: rtl/dr_datapath.sv
module dr_datapath
  import dr_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WIDTH-1:0]  railT,
  input  logic [WIDTH-1:0]  railF,
  input  ctlStrobes_t       strobes,
  output logic              allValid,
  output logic              allZero,
  output logic              anyIllegal,
  output logic [WIDTH-1:0]  dataOut,
  output logic              codeErr
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [WIDTH-1:0] tPipe [SYNC_STAGES];
  logic [WIDTH-1:0] fPipe [SYNC_STAGES];
  logic [WIDTH-1:0] tSync, fSync;
  logic [WIDTH-1:0] bitValid, bitIllegal, bitActive;
  logic [WIDTH-1:0] dataQ;
  logic             errQ;

  // synchronizer chain, one register per stage
  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rstN) begin
          tPipe[s] <= '0;
          fPipe[s] <= '0;
        end else begin
          tPipe[s] <= railT;
          fPipe[s] <= railF;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rstN) begin
          tPipe[s] <= '0;
          fPipe[s] <= '0;
        end else begin
          tPipe[s] <= tPipe[s-1];
          fPipe[s] <= fPipe[s-1];
        end
      end
    end
  end

  assign tSync = tPipe[LAST];
  assign fSync = fPipe[LAST];

  // per-bit code classification
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign bitValid[i]   = tSync[i] ^ fSync[i];
    assign bitIllegal[i] = tSync[i] & fSync[i];
    assign bitActive[i]  = tSync[i] | fSync[i];
  end

  assign allValid   = &bitValid;
  assign allZero    = ~|bitActive;
  assign anyIllegal = |bitIllegal;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataQ <= '0;
    end else if (strobes.captureEn) begin
      dataQ <= tSync;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errQ <= 1'b0;
    end else if (strobes.errSet) begin
      errQ <= 1'b1;
    end
  end

  assign dataOut = dataQ;
  assign codeErr = errQ;
endmodule

// File: rtl/dr_control.sv
module dr_control
  import dr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        allValid,
  input  logic        allZero,
  input  logic        anyIllegal,
  output ctlStrobes_t strobes,
  output logic        ack,
  output logic        outValid
);
  logic mergeQ, pulseQ;
  logic setMerge, clrMerge, mergeNext;

  // hysteretic merge: set on all-valid, clear on all-zero, else hold
  assign setMerge = allValid & ~mergeQ;
  assign clrMerge = allZero & mergeQ;

  always_comb begin
    mergeNext = mergeQ;
    if (setMerge) begin
      mergeNext = 1'b1;
    end else if (clrMerge) begin
      mergeNext = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mergeQ <= 1'b0;
      pulseQ <= 1'b0;
    end else begin
      mergeQ <= mergeNext;
      pulseQ <= setMerge;
    end
  end

  assign strobes.captureEn = setMerge;
  assign strobes.errSet    = anyIllegal;
  assign ack               = mergeQ;
  assign outValid          = pulseQ;
endmodule

// File: rtl/dr_rx.sv
module dr_rx
  import dr_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] railT,
  input  logic [WIDTH-1:0] railF,
  output logic             ack,
  output logic [WIDTH-1:0] dataOut,
  output logic             outValid,
  output logic             codeErr
);
  ctlStrobes_t strobes;
  logic allValid, allZero, anyIllegal;

  dr_datapath #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .railT(railT), .railF(railF),
    .strobes(strobes), .allValid(allValid), .allZero(allZero),
    .anyIllegal(anyIllegal), .dataOut(dataOut), .codeErr(codeErr)
  );

  dr_control u_ctl (
    .clk(clk), .rstN(rstN), .allValid(allValid), .allZero(allZero),
    .anyIllegal(anyIllegal), .strobes(strobes), .ack(ack),
    .outValid(outValid)
  );
endmodule

// File: rtl/dr_rx_chk.sv
module dr_rx_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             ack,
  input logic [WIDTH-1:0] dataOut,
  input logic             outValid,
  input logic             codeErr
);
  // R3: strobe lasts one cycle
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid);
  // R3: strobe coincides with the acknowledge rise
  a_r3_pulse_on_rise: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (ack && $rose(ack)));
  a_r3_rise_has_pulse: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ack) |-> outValid);
  // R6: captured word changes only with a strobe
  a_r6_data_hold: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> $stable(dataOut));
  // R7: error flag is sticky
  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    codeErr |=> codeErr);
  // R5: acknowledge never falls together with a new strobe
  a_r5_fall_quiet: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ack) |-> !outValid);
endmodule

bind dr_rx dr_rx_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rstN(rstN), .ack(ack), .dataOut(dataOut),
  .outValid(outValid), .codeErr(codeErr)
);

// File: tb/sim_dr_rx.sv
`timescale 1ns/1ps
module sim_dr_rx;
  localparam int W = 4;
  localparam logic [W-1:0] MASK = '1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [W-1:0] railT = '0, railF = '0;
  logic ack, outValid, codeErr;
  logic [W-1:0] dataOut;
  int vecs = 0, bad = 0, pulses = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dr_rx #(.WIDTH(W), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rstN(rstN), .railT(railT), .railF(railF), .ack(ack),
    .dataOut(dataOut), .outValid(outValid), .codeErr(codeErr)
  );

  always @(negedge clk) if (rstN && outValid) pulses++;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vecs++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendWord(input logic [W-1:0] v);
    railT = v;
    railF = ~v & MASK;
  endtask

  task automatic spacer();
    railT = '0;
    railF = '0;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    spacer();
    step(3);
    rstN = 1'b1;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      bad++;
      vecs++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

  initial begin
    int p0;
    @(negedge clk);
    chk(ack == 0 && outValid == 0 && codeErr == 0 && dataOut == 0, "R1 in reset", ack, 0);
    doReset();
    chk(ack == 0 && outValid == 0 && codeErr == 0 && dataOut == 0, "R1 after release", ack, 0);
    step(2);

    // exhaustive sweep of words: R2, R3, R9, R5
    for (int v = 0; v < (1 << W); v++) begin
      p0 = pulses;
      sendWord(v[W-1:0]);
      step(2);
      chk(ack == 0, "R2 ack early", ack, 0);
      step(1);
      chk(ack == 1, "R2 ack rise", ack, 1);
      chk(outValid == 1, "R3 pulse with rise", outValid, 1);
      chk(dataOut == v[W-1:0], "R9 decoded word", dataOut, v);
      step(1);
      chk(outValid == 0, "R3 pulse ends", outValid, 0);
      chk(pulses - p0 == 1, "R3 single pulse", pulses - p0, 1);
      spacer();
      step(2);
      chk(ack == 1, "R5 ack held during rtz", ack, 1);
      step(1);
      chk(ack == 0, "R5 ack fall", ack, 0);
      chk(dataOut == v[W-1:0], "R9 word held after rtz", dataOut, v);
      step(1);
    end

    // R4: partial word
    railT = 4'b0101; railF = 4'b0010;
    step(6);
    chk(ack == 0, "R4 partial no ack", ack, 0);
    railF = 4'b1010;
    step(3);
    chk(ack == 1 && dataOut == 4'b0101, "R4 completes", dataOut, 5);
    // R5: partial return to zero
    railT = 4'b0100; railF = 4'b0000;
    step(6);
    chk(ack == 1, "R5 partial rtz holds", ack, 1);
    spacer();
    step(3);
    chk(ack == 0, "R5 full rtz", ack, 0);
    step(1);

    // R6: word swap without return to zero
    sendWord(4'b1001);
    step(4);
    p0 = pulses;
    sendWord(4'b0110);
    step(6);
    chk(pulses == p0, "R6 no new pulse", pulses - p0, 0);
    chk(dataOut == 4'b1001, "R6 data kept", dataOut, 9);
    chk(ack == 1, "R6 ack held", ack, 1);
    spacer();
    step(4);

    // R7: illegal code
    chk(codeErr == 0, "R7 clean before", codeErr, 0);
    railT = 4'b0011; railF = 4'b1110;
    step(2);
    chk(codeErr == 0, "R7 not yet", codeErr, 0);
    step(1);
    chk(codeErr == 1, "R7 err set", codeErr, 1);
    step(3);
    chk(ack == 0, "R7 illegal not valid", ack, 0);
    spacer();
    step(4);
    chk(codeErr == 1, "R7 sticky", codeErr, 1);
    sendWord(4'b0011);
    step(3);
    chk(ack == 1 && codeErr == 1, "R7 sticky after word", codeErr, 1);

    // R8: illegal during return to zero
    railT = 4'b0100; railF = 4'b0100;
    step(6);
    chk(ack == 1, "R8 illegal holds ack", ack, 1);
    spacer();
    step(3);
    chk(ack == 0, "R8 ack falls", ack, 0);

    doReset();
    chk(codeErr == 0 && dataOut == 0, "R1 reset clears err", codeErr, 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule